// File: doc/BRIEF.md
# High-Resolution Edge Delay Scaler

This block places a pin edge inside a loop-resolution period with a resolution of one fast clock. A loop-resolution period lasts lr fast clock periods, where lr is a power of two selected by a three-bit exponent held in the prescale word. A seven-bit fine-delay field is read as a binary fraction of that period. The most significant field bit is worth one half of the period, and each lower bit is worth half of the bit above it. The resulting delay, counted in fast clocks, is the product of lr and that fraction. Any fractional part of the product is discarded, so field bits finer than one fast clock have no effect.

The block is used once per period. A loop-start pulse captures the prescale exponent, the field and the requested pin level. The block then counts fast clocks. On the edge where the count reaches the computed delay, it drives the captured level onto its pin output and raises a one-cycle done flag. A loop-start pulse that arrives before a pending update completes replaces that update.

Top module: `hrdly_edge_scaler`

## Requirements
- R1: During and after a synchronous active-high reset, pin_out is 0, done is 0, and no update is pending. An update that was pending when reset asserted never completes.
- R2: The exponent k is taken from prescale bits 10:8, and lr = 2^k. All other prescale bits have no effect on the delay.
- R3: The delay in fast clocks is floor(hr_field × 2^k / 128). The fractional remainder is truncated, never rounded.
- R4: With prescale = 0x0300 (k = 3, lr = 8) and hr_field = 0x50, the delay is exactly 5 fast clocks.
- R5: If loop_start is sampled high at edge E0 and the computed delay d is nonzero, then pin_out takes the pin_req value sampled at E0 on edge E0+d. done is high for exactly the cycle that follows E0+d. Before E0+d, pin_out holds its old value and done stays low.
- R6: If the computed delay is 0, pin_out takes pin_req and done rises on edge E0 itself.
- R7: A loop_start sampled while an update is pending cancels that update and restarts the count with the newly captured values.
- R8: Changes to pin_req, hr_field or prescale after the loop_start edge do not alter a pending update.
- R9: Without loop_start, and with no update pending, pin_out holds its value and done stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast (high-resolution) clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_start | input | 1 | One-cycle pulse marking the start of a loop-resolution period |
| prescale | input | 16 | Prescale word; bits 10:8 hold the exponent k |
| hr_field | input | 7 | Fine-delay field, read as a binary fraction of the period |
| pin_req | input | 1 | Pin level to apply when the delay expires |
| pin_out | output | 1 | Delayed pin value |
| done | output | 1 | One-cycle flag marking the edge on which pin_out was updated |

## Verification
For each start, the bench computes the delay d from the requirement formula. It then expects the pin change and the done flag to appear just after edge E0+d, or just after E0 itself when d is 0. The inputs are driven on falling edges and the outputs are sampled on falling edges, so each cycle is checked half a period after the edge that produced it. During the waiting cycles, the bench checks after every edge that the pin has not moved and that done is low. In the cycle after the update, it checks that done has fallen again. Cancellation, input changes after the start, and reset during a pending update are each checked cycle by cycle in the same way.

// File: rtl/hrdly_pkg.sv
package hrdly_pkg;
    // widths and field positions
    parameter int FIELD_W = 7;
    parameter int EXP_W   = 3;
    parameter int PS_W    = 16;
    parameter int EXP_LSB = 8;

    localparam int MAX_EXP = (1 << EXP_W) - 1;
    localparam int PROD_W  = FIELD_W + MAX_EXP;
    localparam int CNT_W   = FIELD_W;
    localparam int LR_W    = MAX_EXP + 1;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [EXP_W-1:0]   exp_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [LR_W-1:0]    lr_t;

    typedef struct packed {
        logic active;
        logic level;
        cnt_t target;
        cnt_t cnt;
    } pend_t;

    // delay = floor(field * 2^k / 2^FIELD_W)
    function automatic cnt_t scale_delay(input field_t f, input exp_t k);
        logic [PROD_W-1:0] prod;
        prod = PROD_W'(f) << k;
        return CNT_W'(prod >> FIELD_W);
    endfunction
endpackage

// File: rtl/hrdly_exp_decode.sv
module hrdly_exp_decode
    import hrdly_pkg::*;
(
    input  logic [PS_W-1:0] prescale,
    output exp_t            exp_k,
    output lr_t             lr
);
    always_comb begin
        exp_k = prescale[EXP_LSB +: EXP_W];
        lr    = LR_W'(1) << exp_k;
    end
endmodule

// File: rtl/hrdly_scale.sv
module hrdly_scale
    import hrdly_pkg::*;
(
    input  field_t field,
    input  exp_t   exp_k,
    output cnt_t   delay
);
    always_comb delay = scale_delay(field, exp_k);
endmodule

// File: rtl/hrdly_sched.sv
module hrdly_sched
    import hrdly_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic loop_start,
    input  cnt_t delay,
    input  logic pin_req,
    output logic pin_out,
    output logic done
);
    pend_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            pin_out <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (loop_start) begin
                if (delay == '0) begin
                    pin_out     <= pin_req;
                    done        <= 1'b1;
                    pend.active <= 1'b0;
                end else begin
                    pend.active <= 1'b1;
                    pend.level  <= pin_req;
                    pend.target <= delay;
                    pend.cnt    <= cnt_t'(1);
                end
            end else if (pend.active) begin
                if (pend.cnt == pend.target) begin
                    pin_out     <= pend.level;
                    done        <= 1'b1;
                    pend.active <= 1'b0;
                end else begin
                    pend.cnt <= pend.cnt + 1'b1;
                end
            end
        end
    end

    // R5: the running count never passes its target
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        pend.active |-> (pend.cnt <= pend.target && pend.cnt != '0));

    // R6: a zero delay updates on the start edge
    assert_zero_now_R6: assert property (@(posedge clk) disable iff (rst)
        (loop_start && delay == '0) |=> (done && pin_out == $past(pin_req)));

    // R7: a nonzero start never completes in the next cycle
    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (loop_start && delay != '0) |=> !done);

    // R9: the pin only moves together with done
    assert_pin_moves_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_out) |-> done);
endmodule

// File: rtl/hrdly_edge_scaler.sv
module hrdly_edge_scaler
    import hrdly_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            loop_start,
    input  logic [PS_W-1:0] prescale,
    input  logic [6:0]      hr_field,
    input  logic            pin_req,
    output logic            pin_out,
    output logic            done
);
    exp_t exp_k;
    lr_t  lr;
    cnt_t delay;

    hrdly_exp_decode u_dec (
        .prescale (prescale),
        .exp_k    (exp_k),
        .lr       (lr)
    );

    hrdly_scale u_scale (
        .field (field_t'(hr_field)),
        .exp_k (exp_k),
        .delay (delay)
    );

    hrdly_sched u_sched (
        .clk        (clk),
        .rst        (rst),
        .loop_start (loop_start),
        .delay      (delay),
        .pin_req    (pin_req),
        .pin_out    (pin_out),
        .done       (done)
    );

    // R3: a truncated fraction of the period stays below one full period
    assert_delay_below_period_R3: assert property (@(posedge clk) disable iff (rst)
        loop_start |-> (LR_W'(delay) < lr));

    // R1: no update completes in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) && !loop_start |-> !done);
endmodule

// File: tb/hrdly_edge_scaler_bench.sv
module hrdly_edge_scaler_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        loop_start = 1'b0;
    logic [15:0] prescale = 16'h0;
    logic [6:0]  hr_field = 7'h0;
    logic        pin_req = 1'b0;
    logic        pin_out;
    logic        done;

    int checks = 0;
    int errors = 0;
    logic exp_pin = 1'b0;

    always #5 clk = ~clk;

    hrdly_edge_scaler u_hrdly_edge_scaler (
        .clk(clk), .rst(rst), .loop_start(loop_start), .prescale(prescale),
        .hr_field(hr_field), .pin_req(pin_req), .pin_out(pin_out), .done(done)
    );

    // {prescale, field, expected delay}
    localparam int NV = 11;
    localparam logic [30:0] VEC [NV] = '{
        {16'h0300, 7'h50, 8'd5},    // R4
        {16'h0000, 7'h7F, 8'd0},    // R6
        {16'h0700, 7'h7F, 8'd127},  // R3
        {16'h0700, 7'h01, 8'd1},    // R3
        {16'h0500, 7'h44, 8'd17},   // R3
        {16'h0300, 7'h5F, 8'd5},    // R3 truncation
        {16'hF300, 7'h50, 8'd5},    // R2 upper bits ignored
        {16'h03FF, 7'h20, 8'd2},    // R2 lower bits ignored
        {16'h0100, 7'h40, 8'd1},    // R2
        {16'h0600, 7'h3F, 8'd31},   // R3 truncation
        {16'h0200, 7'h1F, 8'd0}     // R6 truncated to zero
    };

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: {pin_out,done} actual %b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    // start at a falling edge; the start edge E0 is the next rising edge
    task automatic start(input logic [15:0] ps, input logic [6:0] f, input logic lvl);
        prescale   = ps;
        hr_field   = f;
        pin_req    = lvl;
        loop_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        loop_start = 1'b0;
    endtask

    task automatic run_vec(input logic [15:0] ps, input logic [6:0] f, input int d, input string req);
        logic lvl;
        lvl = ~exp_pin;
        start(ps, f, lvl);
        // R8: scramble inputs once the start edge has passed
        prescale = ~ps;
        hr_field = ~f;
        pin_req  = ~lvl;
        if (d == 0) begin
            exp_pin = lvl;
            chk(req, {pin_out, done}, {exp_pin, 1'b1});
        end else begin
            chk(req, {pin_out, done}, {exp_pin, 1'b0});
            for (int i = 1; i <= d; i++) begin
                @(posedge clk); @(negedge clk);
                if (i < d) chk(req, {pin_out, done}, {exp_pin, 1'b0});
                else begin
                    exp_pin = lvl;
                    chk(req, {pin_out, done}, {exp_pin, 1'b1});
                end
            end
        end
        @(posedge clk); @(negedge clk);
        chk("R5 done pulse", {pin_out, done}, {exp_pin, 1'b0});
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", {pin_out, done}, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {pin_out, done}, 2'b00);

        for (int v = 0; v < NV; v++)
            run_vec(VEC[v][30:15], VEC[v][14:8], int'(VEC[v][7:0]), $sformatf("R3 vector %0d", v));

        // R9: idle, pin_req toggling
        for (int i = 0; i < 6; i++) begin
            pin_req = ~pin_req;
            hr_field = 7'(i);
            @(posedge clk); @(negedge clk);
            chk("R9 idle", {pin_out, done}, {exp_pin, 1'b0});
        end

        // R7: first start (d=10, level 1) cancelled by second (d=20, level 0)
        if (exp_pin) run_vec(16'h0000, 7'h00, 0, "R6 pin clear");
        start(16'h0400, 7'h50, 1'b1);  // 80*16/128 = 10
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
        end
        start(16'h0500, 7'h50, 1'b0);  // 80*32/128 = 20
        for (int i = 1; i <= 20; i++) begin
            @(posedge clk); @(negedge clk);
            if (i < 20) chk("R7 cancel", {pin_out, done}, 2'b00);
            else        chk("R7 restart", {pin_out, done}, 2'b01);
        end

        // R1: reset during a pending update
        start(16'h0300, 7'h50, 1'b1);
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 reset pending", {pin_out, done}, 2'b00);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R1 pending dropped", {pin_out, done}, 2'b00);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule